// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplex Mode

This block holds eight bits that are written one at a time. A three-bit index picks the bit, and a single serial data line supplies the value. Two control lines choose how the block behaves on each rising clock edge. The enable is active low and the clear is active high. Together they select one of four operating modes: write one bit, hold everything, route data to one output, or wipe all bits. The outputs come straight from the storage register, so every change appears right after the edge that sampled the inputs.

The block can act as a serial-to-parallel converter, a small scratch register that can be written at random, or a one-of-eight decoder whose selected line carries the data bit. Every input is sampled on the clock edge, so the block does not have the glitch a free-running level latch shows when several index bits change together. Even so, a system should still change the index only in hold mode.

The modes form a four-state machine that is evaluated again on every edge. The states are WRITE (enable low, clear low), HOLD (enable high, clear low), ROUTE (enable low, clear high) and WIPE (enable high, clear high). Any state can move to any other state on the next edge, because the state is taken directly from the two control inputs. A synchronous reset, separate from the clear input, overrides every state.

Top module: `bitlatch8_top`

## Requirements
- R1: While rst is high at a rising edge, all eight outputs are 0 after that edge, whatever the other inputs are.
- R2: WRITE (en_n=0, clr=0): the output bit selected by sel takes the value of din. All other bits keep their values.
- R3: HOLD (en_n=1, clr=0): all eight outputs keep their values, whatever sel and din are.
- R4: ROUTE (en_n=0, clr=1): the selected output equals din and every other output is 0.
- R5: WIPE (en_n=1, clr=1): all eight outputs become 0.
- R6: sel is an unsigned index with bit 0 as its least significant bit, so the value n selects output bit q[n].
- R7: The pattern left by a ROUTE cycle stays stored and is held by a following HOLD cycle.
- R8: Reset has priority over every mode, including WRITE with din=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| sel | input | 3 | Bit index, bit 0 least significant |
| en_n | input | 1 | Active-low write enable |
| clr | input | 1 | Active-high clear |
| q | output | 8 | Stored bits |

## Verification
Assertions check these rules on every cycle: HOLD leaves the outputs stable, WIPE and reset zero them, WRITE changes at most one bit and the selected bit takes din, and ROUTE leaves at most one bit set, at the selected index. Some behaviour needs a known history and only the bench's scenarios can show it. That covers the exact value of every unselected bit after WRITE, a ROUTE pattern that survives into HOLD, and the mapping of each index value to its own output line.

// File: rtl/bitlatch8_pkg.sv
package bitlatch8_pkg;
    typedef enum logic [1:0] {
        ST_WRITE = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ROUTE = 2'd2,
        ST_WIPE  = 2'd3
    } bl_state_e;
endpackage

// File: rtl/bl_mode_decode.sv
module bl_mode_decode
    import bitlatch8_pkg::*;
(
    input  logic      en_n,
    input  logic      clr,
    output bl_state_e state
);
    always_comb begin
        unique case ({clr, en_n})
            2'b00:   state = ST_WRITE;
            2'b01:   state = ST_HOLD;
            2'b10:   state = ST_ROUTE;
            default: state = ST_WIPE;
        endcase
    end
endmodule

// File: rtl/bl_index_decode.sv
module bl_index_decode #(
    parameter int IDX_W = 3,
    localparam int NBITS = 1 << IDX_W
) (
    input  logic [IDX_W-1:0] sel,
    output logic [NBITS-1:0] hit
);
    for (genvar i = 0; i < NBITS; i++) begin : g_hit
        assign hit[i] = (sel == IDX_W'(i));
    end
endmodule

// File: rtl/bl_store.sv
module bl_store
    import bitlatch8_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int NBITS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  bl_state_e        state,
    input  logic             din,
    input  logic [IDX_W-1:0] sel,
    input  logic [NBITS-1:0] hit,
    output logic [NBITS-1:0] q
);
    logic [NBITS-1:0] q_nxt;
    logic [NBITS-1:0] din_fan;

    assign din_fan = {NBITS{din}};

    always_comb begin
        unique case (state)
            ST_WRITE: q_nxt = (q & ~hit) | (hit & din_fan);
            ST_HOLD:  q_nxt = q;
            ST_ROUTE: q_nxt = hit & din_fan;
            ST_WIPE:  q_nxt = '0;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) rst |=> (q == '0));
    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |=> $stable(q));
    // R5
    wipe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WIPE) |=> (q == '0));
    // R2
    write_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |=> (q[$past(sel)] == $past(din)));
    // R2
    write_single_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE) |=> ($countones(q ^ $past(q)) <= 1));
    // R4
    route_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROUTE) |=> ($onehot0(q) && (q[$past(sel)] == $past(din))));
endmodule

// File: rtl/bitlatch8_top.sv
module bitlatch8_top
    import bitlatch8_pkg::*;
#(
    parameter int IDX_W = 3,
    localparam int NBITS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [IDX_W-1:0] sel,
    input  logic             en_n,
    input  logic             clr,
    output logic [NBITS-1:0] q
);
    bl_state_e        state;
    logic [NBITS-1:0] hit;

    bl_mode_decode u_mode (
        .en_n  (en_n),
        .clr   (clr),
        .state (state)
    );

    bl_index_decode #(.IDX_W(IDX_W)) u_idx (
        .sel (sel),
        .hit (hit)
    );

    bl_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .state (state),
        .din   (din),
        .sel   (sel),
        .hit   (hit),
        .q     (q)
    );
endmodule

// File: tb/sim_bitlatch8_top.sv
module sim_bitlatch8_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       en_n = 1'b1;
    logic       clr = 1'b0;
    logic [7:0] q;
    int         applied = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    bitlatch8_top u0 (
        .clk(clk), .rst(rst), .din(din), .sel(sel),
        .en_n(en_n), .clr(clr), .q(q)
    );

    // vector fields: [13]=en_n [12]=clr [11:9]=sel [8]=din [7:0]=expected q
    localparam int NV = 16;
    localparam logic [13:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 1'b1, 8'h01},  // R2 write bit0
        {1'b0, 1'b0, 3'd7, 1'b1, 8'h81},  // R2 R6 write bit7
        {1'b0, 1'b0, 3'd3, 1'b1, 8'h89},  // R2
        {1'b1, 1'b0, 3'd5, 1'b1, 8'h89},  // R3 hold ignores sel/din
        {1'b0, 1'b0, 3'd0, 1'b0, 8'h88},  // R2 clear single bit
        {1'b0, 1'b1, 3'd2, 1'b1, 8'h04},  // R4 route
        {1'b1, 1'b0, 3'd6, 1'b0, 8'h04},  // R7 pattern held
        {1'b0, 1'b1, 3'd5, 1'b0, 8'h00},  // R4 route zero
        {1'b0, 1'b0, 3'd5, 1'b1, 8'h20},  // R2
        {1'b0, 1'b0, 3'd6, 1'b1, 8'h60},  // R2
        {1'b1, 1'b1, 3'd1, 1'b1, 8'h00},  // R5 wipe
        {1'b0, 1'b0, 3'd1, 1'b1, 8'h02},  // R2
        {1'b0, 1'b0, 3'd4, 1'b1, 8'h12},  // R2
        {1'b0, 1'b1, 3'd7, 1'b1, 8'h80},  // R4
        {1'b0, 1'b0, 3'd2, 1'b1, 8'h84},  // R2
        {1'b1, 1'b0, 3'd0, 1'b0, 8'h84}   // R3
    };

    task automatic check(input logic [7:0] exp, input string req);
        applied++;
        if (q !== exp) begin
            bad++;
            $display("FAIL %s: q=%02h expected %02h", req, q, exp);
        end
    endtask

    task automatic step(input logic e, input logic c, input logic [2:0] s,
                        input logic d, input logic r);
        @(negedge clk);
        en_n = e; clr = c; sel = s; din = d; rst = r;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(8'h00, "R1 reset state");
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8], 1'b0);
            check(VEC[i][7:0], "R2/R3/R4/R5/R7 table");
        end
        // R6: each index drives its own line in ROUTE
        for (int n = 0; n < 8; n++) begin
            step(1'b0, 1'b1, 3'(n), 1'b1, 1'b0);
            check(8'h01 << n, "R6 index map");
        end
        // R8: reset beats WRITE with din=1
        step(1'b0, 1'b0, 3'd3, 1'b1, 1'b0);
        step(1'b0, 1'b0, 3'd6, 1'b1, 1'b0);
        check(8'hC8, "R2 setup");
        step(1'b0, 1'b0, 3'd1, 1'b1, 1'b1);
        check(8'h00, "R8 reset priority");
        step(1'b1, 1'b0, 3'd1, 1'b1, 1'b0);
        check(8'h00, "R1 after reset hold");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: q=%02h expected completion", q);
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end
endmodule